// File: doc/BRIEF.md
# Register-Map I2C Target with Per-Byte Address Validity

This block lets an external I2C controller read and write a small set of on-chip registers. It watches SCL and SDA through synchronizers clocked by a fast system clock and only ever pulls SDA low through an open-drain enable; SCL is never driven, so the clock is never stretched. After START, the block compares a 7-bit device address with its parameter value. In a write, the first byte after the device address loads an 8-bit register pointer. Each later byte is written at the pointer and then the pointer advances. In a read, bytes are returned from the pointer location, again advancing after each byte. A repeated START switches from the pointer-setting write to a read.

The register map is a parameter: a list of implemented addresses, each marked writable or read-only. Pointer values outside that list do not abort a transfer. The byte that names or writes such an address is refused with a NACK, reads from it give 0x00, and the pointer still steps and wraps from 0xFF to 0x00. Acknowledges resume as soon as the pointer reaches a register that accepts the access. Writes leave the block as one-cycle strobes with address and data. Read data comes back on an input that is addressed by the live pointer. A one-cycle done pulse marks each STOP that closes a transaction in which the block was addressed.

Top module: `i2c_regmap_target`

## Requirements
- R1: A device-address byte whose upper 7 bits equal DEV_ADDR (bit 0: 0 = write, 1 = read) is ACKed. Any other value is NACKed, and the block then drives nothing and writes nothing until the next START or STOP.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START begins a new device-address phase and keeps the pointer. `xfer_done` pulses for one cycle after a STOP if the block was addressed since the previous STOP.
- R3: `sda_oe` changes only while SCL is low, except when it is released at a START or STOP.
- R4: An ACK holds SDA low for the whole high phase of the ninth clock.
- R5: The first byte after a write-mode device address loads the pointer. It is ACKed when it names an implemented register and NACKed when it does not.
- R6: A data byte written while the pointer names a writable register produces one `reg_wr_stb` pulse carrying the pointer and the byte, and is ACKed.
- R7: A data byte written while the pointer names an unimplemented or read-only register is NACKed and produces no strobe. The pointer still advances.
- R8: Each read byte is sent MSB first. It is `reg_rd_data` (sampled at `reg_rd_addr` = pointer) when the pointer names an implemented register, and 0x00 otherwise. The pointer advances after every byte read.
- R9: The pointer wraps from 0xFF to 0x00 in both reads and writes.
- R10: When the controller NACKs a read byte, the block releases SDA and does not drive it again until the next START or STOP.
- R11: Asynchronous reset puts the block in idle with SDA released and no strobe or done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_rd_addr | output | 8 | Current register pointer, used to select read data |
| reg_rd_data | input | 8 | Register contents at `reg_rd_addr` |
| reg_wr_stb | output | 1 | One-cycle write strobe |
| reg_wr_addr | output | 8 | Register address of the write |
| reg_wr_data | output | 8 | Data byte of the write |
| xfer_done | output | 1 | One-cycle pulse after a STOP ending an addressed transaction |

## Verification
Every bus event reaches the logic two to three system clocks after the pad changes, because of the synchronizer and the edge register. The ACK and data outputs are registered once more, so they settle about four clocks after the SCL edge that launches them. The bench keeps each SCL quarter-phase at eight clocks, so SDA is sampled well inside the high phase, both at its start and near its end for ACKs. Write strobes and done pulses are counted as they occur, and the counts are compared once the byte or STOP that caused them has finished. Register contents are checked through a later read over the bus.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_IGNORE
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_DEV, PH_REG, PH_WR
  } rx_phase_e;

  // pointer step with natural 8-bit wrap
  function automatic logic [BYTE_W-1:0] ptr_next(input logic [BYTE_W-1:0] p);
    return p + 1'b1;
  endfunction

  // byte returned on a read: holes read as zero
  function automatic logic [BYTE_W-1:0] rd_byte(input logic hit, input logic [BYTE_W-1:0] d);
    return hit ? d : '0;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_d     = scl_q[STAGES];
  assign sda_d     = sda_q[STAGES];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & ~sda_s & sda_d;
  assign stop_det  = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/i2c_reg_decode.sv
module i2c_reg_decode #(
  parameter int                    NUM_REGS     = 5,
  parameter logic [NUM_REGS*8-1:0] REG_ADDRS    = '0,
  parameter logic [NUM_REGS-1:0]   REG_WRITABLE = '0
) (
  input  logic [7:0] addr,
  output logic       hit,
  output logic       writable
);
  always_comb begin
    hit      = 1'b0;
    writable = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (REG_ADDRS[i*8 +: 8] == addr) begin
        hit      = 1'b1;
        writable = REG_WRITABLE[i];
      end
    end
  end
endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]            DEV_ADDR     = 7'h2A,
  parameter int                    SYNC_STAGES  = 2,
  parameter int                    NUM_REGS     = 5,
  parameter logic [NUM_REGS*8-1:0] REG_ADDRS    = {8'hFF, 8'h12, 8'h11, 8'h10, 8'h00},
  parameter logic [NUM_REGS-1:0]   REG_WRITABLE = 5'b10110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_rd_addr,
  input  logic [BYTE_W-1:0] reg_rd_data,
  output logic              reg_wr_stb,
  output logic [BYTE_W-1:0] reg_wr_addr,
  output logic [BYTE_W-1:0] reg_wr_data,
  output logic              xfer_done
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  tgt_state_e        state;
  rx_phase_e         phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_rdy, rd_mode, selected, mack;
  logic [BYTE_W-1:0] shreg, tx_sh, ptr;
  logic [BYTE_W-1:0] dec_addr, tx_load;
  logic              dec_hit, dec_wr, wr_accept;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // the pointer byte is decoded while it is still in the shift register
  assign dec_addr = (state == ST_RX && phase == PH_REG) ? shreg : ptr;

  i2c_reg_decode #(
    .NUM_REGS(NUM_REGS), .REG_ADDRS(REG_ADDRS), .REG_WRITABLE(REG_WRITABLE)
  ) dec_i (
    .addr(dec_addr), .hit(dec_hit), .writable(dec_wr)
  );

  assign tx_load     = rd_byte(dec_hit, reg_rd_data);
  assign wr_accept   = dec_hit & dec_wr;
  assign reg_rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      phase       <= PH_DEV;
      bit_cnt     <= '0;
      byte_rdy    <= 1'b0;
      rd_mode     <= 1'b0;
      selected    <= 1'b0;
      mack        <= 1'b0;
      shreg       <= '0;
      tx_sh       <= '0;
      ptr         <= '0;
      sda_oe      <= 1'b0;
      reg_wr_stb  <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
      xfer_done   <= 1'b0;
    end else begin
      reg_wr_stb <= 1'b0;
      xfer_done  <= 1'b0;
      if (stop_det) begin
        xfer_done <= selected;
        selected  <= 1'b0;
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
      end else if (start_det) begin
        state    <= ST_RX;
        phase    <= PH_DEV;
        bit_cnt  <= '0;
        byte_rdy <= 1'b0;
        sda_oe   <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == CNT_W'(BYTE_W-1)) byte_rdy <= 1'b1;
            end else if (scl_fall && byte_rdy) begin
              byte_rdy <= 1'b0;
              state    <= ST_ACK;
              case (phase)
                PH_DEV: begin
                  if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                    selected <= 1'b1;
                    rd_mode  <= shreg[0];
                    sda_oe   <= 1'b1;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                PH_REG: begin
                  ptr    <= shreg;
                  sda_oe <= dec_hit;
                end
                default: begin
                  sda_oe <= wr_accept;
                  if (wr_accept) begin
                    reg_wr_stb  <= 1'b1;
                    reg_wr_addr <= ptr;
                    reg_wr_data <= shreg;
                  end
                  ptr <= ptr_next(ptr);
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (phase == PH_DEV && rd_mode) begin
                state  <= ST_TX;
                tx_sh  <= tx_load;
                sda_oe <= ~tx_load[BYTE_W-1];
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
                phase  <= (phase == PH_DEV) ? PH_REG : PH_WR;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
                ptr    <= ptr_next(ptr);
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe  <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                state   <= ST_TX;
                bit_cnt <= '0;
                tx_sh   <= tx_load;
                sda_oe  <= ~tx_load[BYTE_W-1];
              end else begin
                state  <= ST_IGNORE;
                sda_oe <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: the output only moves while SCL is low, bar bus-condition release
  p_sda_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

  // R4: no movement of SDA during the high phase of the acknowledge clock
  p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK && scl_s && $past(scl_s) && !stop_det && !start_det) |-> $stable(sda_oe));

  // R1 / R10: a deselected or finished target stays silent
  p_ignore_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> (!sda_oe && !reg_wr_stb));

  // R2: the done pulse follows a detected STOP
  p_done_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(stop_det));

  // R6: the pointer has already moved past the address being written
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |-> (ptr == ptr_next(reg_wr_addr)));
endmodule

// File: tb/i2c_regmap_target_tb.sv
module i2c_regmap_target_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  wire  sda_oe;
  wire  [7:0] reg_rd_addr;
  wire  [7:0] reg_rd_data;
  wire  reg_wr_stb;
  wire  [7:0] reg_wr_addr, reg_wr_data;
  wire  xfer_done;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  int wr_count = 0, done_count = 0, r3_viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] mem [256];

  always #10 clk = ~clk;

  i2c_regmap_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .reg_wr_stb(reg_wr_stb), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .xfer_done(xfer_done)
  );

  assign reg_rd_data = mem[reg_rd_addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      mem[8'h00] <= 8'hA5;
      mem[8'h12] <= 8'h3C;
      mem[8'h40] <= 8'h77;
      mem[8'h0F] <= 8'h66;
    end else begin
      if (reg_wr_stb) begin
        mem[reg_wr_addr] <= reg_wr_data;
        wr_count <= wr_count + 1;
      end
      if (xfer_done) done_count <= done_count + 1;
    end
  end

  // R3 monitor against the raw SCL line
  always @(negedge clk) begin
    if (rst_n && scl_m && sda_oe !== prev_oe) r3_viol <= r3_viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(Q); scl_m = 1'b1; waitq(Q);
    sda_m = 1'b0; waitq(Q); scl_m = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(Q); scl_m = 1'b1; waitq(Q);
    sda_m = 1'b1; waitq(2*Q);
  endtask

  // returns {ack at start of high phase, ack at end of high phase}
  task automatic send_byte(input logic [7:0] b, output logic [1:0] ak);
    logic a0, a1;
    for (int i = 7; i >= 0; i--) begin
      waitq(Q); sda_m = b[i]; waitq(Q);
      scl_m = 1'b1; waitq(2*Q); scl_m = 1'b0;
    end
    waitq(Q); sda_m = 1'b1; waitq(Q);
    scl_m = 1'b1; waitq(1); a0 = ~sda_line;
    waitq(2*Q-2); a1 = ~sda_line; waitq(1);
    scl_m = 1'b0; waitq(Q);
    ak = {a0, a1};
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(2*Q); scl_m = 1'b1; waitq(Q);
      b[i] = sda_line; waitq(Q); scl_m = 1'b0;
    end
    waitq(Q); sda_m = ~give_ack; waitq(Q);
    scl_m = 1'b1; waitq(2*Q); scl_m = 1'b0; waitq(Q);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // {reg addr, write data, reg-byte ack, data ack, readback}
  localparam logic [25:0] VEC [5] = '{
    {8'h10, 8'h5A, 1'b1, 1'b1, 8'h5A},
    {8'h11, 8'hC3, 1'b1, 1'b1, 8'hC3},
    {8'h12, 8'h99, 1'b1, 1'b0, 8'h3C},
    {8'h40, 8'h11, 1'b0, 1'b0, 8'h00},
    {8'h00, 8'h22, 1'b1, 1'b0, 8'hA5}
  };

  localparam logic [7:0] DEV_W = 8'h54;
  localparam logic [7:0] DEV_R = 8'h55;

  initial begin
    waitq(Q * 800000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [1:0] ak;
    logic [7:0] rb;
    int exp_done, wr0;
    exp_done = 0;
    waitq(3);
    // R11: reset state
    chk("R11 sda_oe in reset", sda_oe, 0);
    chk("R11 wr_stb in reset", reg_wr_stb, 0);
    chk("R11 done in reset", xfer_done, 0);
    rst_n = 1'b1;
    waitq(4);

    for (int v = 0; v < 5; v++) begin
      wr0 = wr_count;
      bus_start();
      send_byte(DEV_W, ak); chk("R1 dev ack", ak, 2'b11);
      send_byte(VEC[v][25:18], ak); chk("R5 reg byte ack", ak, VEC[v][9] ? 2'b11 : 2'b00);
      send_byte(VEC[v][17:10], ak); chk("R6/R7 data ack", ak, VEC[v][8] ? 2'b11 : 2'b00);
      chk("R6/R7 strobe count", wr_count - wr0, VEC[v][8] ? 1 : 0);
      bus_stop(); exp_done++;
      chk("R2 done after stop", done_count, exp_done);
      bus_start();
      send_byte(DEV_W, ak);
      send_byte(VEC[v][25:18], ak);
      bus_start();
      send_byte(DEV_R, ak); chk("R2 repeated start read ack", ak, 2'b11);
      recv_byte(1'b0, rb); chk("R8 readback", rb, VEC[v][7:0]);
      bus_stop(); exp_done++;
    end

    // R1: foreign device address is refused and later bytes are ignored
    wr0 = wr_count;
    bus_start();
    send_byte(8'h56, ak); chk("R1 foreign addr nack", ak, 2'b00);
    send_byte(8'h10, ak); chk("R1 ignored byte", ak, 2'b00);
    send_byte(8'hEE, ak); chk("R1 ignored data", ak, 2'b00);
    chk("R1 no write", wr_count - wr0, 0);
    bus_stop();
    chk("R2 no done when unaddressed", done_count, exp_done);

    // R5 R7 R6 R9: page write across holes and the wrap point
    wr0 = wr_count;
    bus_start();
    send_byte(DEV_W, ak);
    send_byte(8'hFE, ak); chk("R5 invalid pointer nack", ak, 2'b00);
    send_byte(8'h81, ak); chk("R7 hole write nack", ak, 2'b00);
    send_byte(8'h82, ak); chk("R6 write at 0xFF ack", ak, 2'b11);
    send_byte(8'h83, ak); chk("R7 read-only 0x00 nack after wrap R9", ak, 2'b00);
    send_byte(8'h84, ak); chk("R7 hole 0x01 nack", ak, 2'b00);
    bus_stop(); exp_done++;
    chk("R6 single strobe", wr_count - wr0, 1);

    // R8 R9 R10: read across the wrap, then controller NACK
    bus_start();
    send_byte(DEV_W, ak);
    send_byte(8'hFF, ak); chk("R5 valid pointer ack", ak, 2'b11);
    bus_start();
    send_byte(DEV_R, ak);
    recv_byte(1'b1, rb); chk("R6 stored at 0xFF", rb, 8'h82);
    recv_byte(1'b1, rb); chk("R9 wrapped read 0x00 R7 unchanged", rb, 8'hA5);
    recv_byte(1'b0, rb); chk("R8 hole reads zero", rb, 8'h00);
    recv_byte(1'b0, rb); chk("R10 released after nack", rb, 8'hFF);
    bus_stop(); exp_done++;

    // R8: read begun at an invalid pointer still runs and hole masks data
    bus_start();
    send_byte(DEV_W, ak);
    send_byte(8'h0F, ak); chk("R5 pointer 0x0F nack", ak, 2'b00);
    bus_start();
    send_byte(DEV_R, ak);
    recv_byte(1'b1, rb); chk("R8 hole 0x0F reads zero", rb, 8'h00);
    recv_byte(1'b0, rb); chk("R8 valid 0x10 after hole", rb, 8'h5A);
    bus_stop(); exp_done++;
    chk("R2 done count", done_count, exp_done);
    chk("R3 no SDA change while SCL high", r3_viol, 0);

    // R11: asynchronous reset during an ACK releases SDA
    bus_start();
    for (int i = 7; i >= 0; i--) begin
      waitq(Q); sda_m = DEV_W[i]; waitq(Q);
      scl_m = 1'b1; waitq(2*Q); scl_m = 1'b0;
    end
    waitq(Q); sda_m = 1'b1;
    chk("R4 ack driven before reset", sda_oe, 1);
    rst_n = 1'b0; waitq(1);
    chk("R11 reset releases SDA", sda_oe, 0);
    scl_m = 1'b1; waitq(Q);
    rst_n = 1'b1; waitq(Q);
    chk("R11 no done after reset", xfer_done, 0);
    report();
  end
endmodule